// File: doc/BRIEF.md
# Daisy-Chain SPI Transaction Sequencer

This block sits on the controller side of a chain of SPI devices. The chain is wired in series: the controller's serial output feeds the first device, and each device's output feeds the next. The output of the last device returns to the controller's serial input. A client sets a device count, a read or write flag and one register address and one data word for every position in the chain. It then pulses `start`. The block drives one complete chip-select frame. The frame opens with a header word that tells the chain how long it is. One address word per device follows, and then one data word per device. Both of those groups begin with the device that sits last in the chain. A read frame appends extra all-zero words so that the read results can come back.

The block shifts in the returned serial stream during the same frame. It keeps the final N words of that stream and puts each one into a per-device result slot. A word tagged as a status report also yields a set of fault flags for that device. Long chains add output delay at every stage. For that reason the serial clock half-period is programmable, and the point where the input is sampled can be pushed later by a few system clocks.

Device index 0 is the device whose input is connected to the controller's serial output. Index N-1 is the device that drives the controller's serial input. The parameter `MAX_DEV` must lie between 1 and 31.

Top module: `dchain_seq`

## Requirements
- R1: The first word of every frame is the header: bits 15:14 = 01, bits 13:5 = 0, bits 4:0 = device count N.
- R2: A `start` with `dev_cnt` of 0 or above `MAX_DEV` is ignored: `busy` stays low, `spi_cs_n` stays high and no `done` follows. An accepted `start` raises `busy` on the next cycle.
- R3: Words 1..N of the frame carry the addresses in the order index N-1 down to index 0.
- R4: In each address word, bit 15 equals `rd_nwr` (1 = read), whatever bit 15 of `addr_in` holds. Bits 14:0 are copied from `addr_in`.
- R5: Words N+1..2N carry `wdata_in` in the order index N-1 down to index 0. A write frame has 2N+1 words. A read frame adds N all-zero words, for 3N+1 words in total.
- R6: The serial clock idles low. Words go out MSB first. `spi_mosi` changes only after a falling edge. Each high and low phase lasts `sclk_half` system clocks, and a value of 0 counts as 1.
- R7: `spi_miso` is sampled `sample_dly` system clocks after the clock edge that raises `spi_sclk`.
- R8: Of the received words, only the last N are kept. The k-th of them (k from 0) is written to `rdata_out[N-1-k]`.
- R9: A kept word whose bits 15:14 are 11 sets `status_out` for its index and places its bits 13:8 in `fault_out`. Any other kept word clears both. At a frame start all status and fault flags are cleared.
- R10: `spi_cs_n` is low for the whole frame. It is then high for at least 2×`sclk_half` system clocks before `done` pulses for one cycle. `busy` falls in the cycle in which `done` is high.
- R11: A `start` that arrives while `busy` is high has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a transaction |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| dev_cnt | input | 5 | Number of devices in the chain |
| sclk_half | input | HALF_W | Serial clock half-period in system clocks |
| sample_dly | input | DLY_W | Input sample delay after the rising edge |
| addr_in | input | MAX_DEV×16 | Per-device register address words |
| wdata_in | input | MAX_DEV×16 | Per-device data words |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata_out | output | MAX_DEV×16 | Per-device received words |
| status_out | output | MAX_DEV | Received word was a status report |
| fault_out | output | MAX_DEV×6 | Per-device fault flags |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the first device |
| spi_miso | input | 1 | Serial data from the last device |

## Verification
The hardest case to reach is a late sample point combined with the end of a frame. When `sample_dly` is close to a half-period, the final bits are still in the sample delay line after the last falling edge. A wrong design would then raise chip select or start the gap count too early and lose the last kept word. The stimulus table pairs large delays with the longest read frames. The bench's chain model changes its output only on falling edges, so any early close or misaligned sample leaves a wrong word in a result slot. A second start request is also sent in the middle of a frame. Its device count gives a different word total, so any change to the running frame shows up in the captured frame length.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int SEG_W = 16;
    localparam int CNT_W = 5;
    localparam int FLT_W = 6;

    localparam logic [1:0] ID_HDR  = 2'b01;
    localparam logic [1:0] ID_STAT = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_TAIL,
        ST_GAP
    } seq_st_t;

    typedef struct packed {
        logic             hit;
        logic [FLT_W-1:0] flt;
    } stat_t;

    // Chain-length word that opens every frame.
    function automatic logic [SEG_W-1:0] mk_header(input logic [CNT_W-1:0] n);
        return {ID_HDR, 9'b0, n};
    endfunction

    // The direction flag overrides the top bit of the supplied address.
    function automatic logic [SEG_W-1:0] mk_addr(input logic [SEG_W-1:0] a, input logic rd);
        return {rd, a[SEG_W-2:0]};
    endfunction

    function automatic stat_t decode_stat(input logic [SEG_W-1:0] w);
        stat_t r;
        r.hit = (w[SEG_W-1:SEG_W-2] == ID_STAT);
        r.flt = r.hit ? w[SEG_W-3:SEG_W-2-FLT_W] : '0;
        return r;
    endfunction

endpackage

// File: rtl/dchain_sclk_gen.sv
module dchain_sclk_gen #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [HALF_W-1:0] half,
    output logic              sclk,
    output logic              rise,
    output logic              fall
);
    logic [HALF_W-1:0] cnt;
    logic              tick;

    assign tick = en && (cnt == half - 1'b1);
    assign rise = tick && !sclk;
    assign fall = tick && sclk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: strobes line up with the level the pin takes next
    a_r6_rise_level: assert property (@(posedge clk) disable iff (rst) rise |=> sclk);
    a_r6_fall_level: assert property (@(posedge clk) disable iff (rst) fall |=> !sclk);

endmodule

// File: rtl/dchain_rx_align.sv
module dchain_rx_align
    import dcs_pkg::*;
#(
    parameter int MAX_DEV = 8,
    parameter int DLY_W   = 3,
    parameter int SEG_CW  = 5,
    parameter int IDX_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clear,
    input  logic                            rise,
    input  logic [DLY_W-1:0]                dly,
    input  logic                            miso,
    input  logic [SEG_CW-1:0]               total,
    input  logic [SEG_CW-1:0]               win,
    output logic [MAX_DEV-1:0][SEG_W-1:0]   rdata,
    output logic [MAX_DEV-1:0]              status,
    output logic [MAX_DEV-1:0][FLT_W-1:0]   fault,
    output logic                            all_rx
);
    localparam int DL_N  = 1 << DLY_W;
    localparam int BIT_W = $clog2(SEG_W);

    logic [DL_N-1:1]   dl_q;
    logic [DL_N-1:0]   dl_vec;
    logic              strobe;
    logic [SEG_W-1:0]  sh;
    logic [SEG_W-1:0]  word;
    logic [BIT_W-1:0]  bitc;
    logic [SEG_CW-1:0] rx_seg;
    logic              last_bit;
    logic              in_win;
    logic [IDX_W-1:0]  idx;
    stat_t             st;

    assign dl_vec   = {dl_q, rise};
    assign strobe   = dl_vec[dly];
    assign word     = {sh[SEG_W-2:0], miso};
    assign last_bit = (bitc == BIT_W'(SEG_W - 1));
    assign in_win   = (rx_seg >= win);
    assign idx      = IDX_W'(total - 1'b1 - rx_seg);
    assign st       = decode_stat(word);
    assign all_rx   = (rx_seg == total);

    always_ff @(posedge clk) begin
        if (rst) begin
            dl_q   <= '0;
            sh     <= '0;
            bitc   <= '0;
            rx_seg <= '0;
            rdata  <= '0;
            status <= '0;
            fault  <= '0;
        end else begin
            dl_q <= dl_vec[DL_N-2:0];
            if (clear) begin
                sh     <= '0;
                bitc   <= '0;
                rx_seg <= '0;
                status <= '0;
                fault  <= '0;
            end else if (strobe) begin
                sh <= word;
                if (last_bit) begin
                    bitc   <= '0;
                    rx_seg <= rx_seg + 1'b1;
                    if (in_win) begin
                        rdata[idx]  <= word;
                        status[idx] <= st.hit;
                        fault[idx]  <= st.flt;
                    end
                end else begin
                    bitc <= bitc + 1'b1;
                end
            end
        end
    end

    // R8: no word completes beyond the frame's word count
    a_r8_no_extra_word: assert property (@(posedge clk) disable iff (rst)
        (strobe && last_bit && !clear) |-> (rx_seg < total));

    // R9: a cleared status slot never reports fault bits
    generate
        for (genvar g = 0; g < MAX_DEV; g++) begin : g_flt_chk
            a_r9_fault_needs_status: assert property (@(posedge clk) disable iff (rst)
                !status[g] |-> (fault[g] == '0));
        end
    endgenerate

endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
    import dcs_pkg::*;
#(
    parameter int MAX_DEV = 8,
    parameter int HALF_W  = 8,
    parameter int DLY_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic                            rd_nwr,
    input  logic [CNT_W-1:0]                dev_cnt,
    input  logic [HALF_W-1:0]               sclk_half,
    input  logic [DLY_W-1:0]                sample_dly,
    input  logic [MAX_DEV-1:0][SEG_W-1:0]   addr_in,
    input  logic [MAX_DEV-1:0][SEG_W-1:0]   wdata_in,
    output logic                            busy,
    output logic                            done,
    output logic [MAX_DEV-1:0][SEG_W-1:0]   rdata_out,
    output logic [MAX_DEV-1:0]              status_out,
    output logic [MAX_DEV-1:0][FLT_W-1:0]   fault_out,
    output logic                            spi_sclk,
    output logic                            spi_cs_n,
    output logic                            spi_mosi,
    input  logic                            spi_miso
);
    localparam int SEG_CW = $clog2(3 * MAX_DEV + 2);
    localparam int BIT_W  = $clog2(SEG_W);
    localparam int IDX_W  = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1;
    localparam logic [CNT_W-1:0] MAX_N = CNT_W'(MAX_DEV);

    seq_st_t           state;
    logic [CNT_W-1:0]  n_q;
    logic              rd_q;
    logic [HALF_W-1:0] half_q;
    logic [DLY_W-1:0]  dly_q;
    logic [SEG_CW-1:0] tx_seg;
    logic [BIT_W-1:0]  tx_bit;
    logic [HALF_W:0]   gap_cnt;
    logic              done_q;

    logic [SEG_CW-1:0] n_ext, total, seg_last, win;
    logic [HALF_W:0]   gap_last;
    logic              accept, rise, fall, all_rx;
    logic [SEG_W-1:0]  cur_seg;
    logic [IDX_W-1:0]  a_idx, d_idx;

    assign accept   = start && (state == ST_IDLE) && (dev_cnt != '0) && (dev_cnt <= MAX_N);
    assign n_ext    = SEG_CW'(n_q);
    assign total    = rd_q ? SEG_CW'(3 * n_ext + 1) : SEG_CW'(2 * n_ext + 1);
    assign seg_last = total - 1'b1;
    assign win      = total - n_ext;
    assign gap_last = {half_q, 1'b0} - 1'b1;
    assign a_idx    = IDX_W'(n_ext - tx_seg);
    assign d_idx    = IDX_W'((n_ext << 1) - tx_seg);

    // Word on the wire: header, addresses far-first, data far-first, flush.
    always_comb begin
        if (tx_seg == '0)
            cur_seg = mk_header(n_q);
        else if (tx_seg <= n_ext)
            cur_seg = mk_addr(addr_in[a_idx], rd_q);
        else if (tx_seg <= (n_ext << 1))
            cur_seg = wdata_in[d_idx];
        else
            cur_seg = '0;
    end

    assign spi_mosi = (state == ST_RUN) && cur_seg[BIT_W'(SEG_W - 1) - tx_bit];
    assign spi_cs_n = (state == ST_IDLE) || (state == ST_GAP);
    assign busy     = (state != ST_IDLE);
    assign done     = done_q;

    dchain_sclk_gen #(.HALF_W(HALF_W)) u_sclk (
        .clk  (clk),
        .rst  (rst),
        .en   (state == ST_RUN),
        .half (half_q),
        .sclk (spi_sclk),
        .rise (rise),
        .fall (fall)
    );

    dchain_rx_align #(
        .MAX_DEV (MAX_DEV),
        .DLY_W   (DLY_W),
        .SEG_CW  (SEG_CW),
        .IDX_W   (IDX_W)
    ) u_rx (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .rise   (rise),
        .dly    (dly_q),
        .miso   (spi_miso),
        .total  (total),
        .win    (win),
        .rdata  (rdata_out),
        .status (status_out),
        .fault  (fault_out),
        .all_rx (all_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            n_q     <= '0;
            rd_q    <= 1'b0;
            half_q  <= HALF_W'(1);
            dly_q   <= '0;
            tx_seg  <= '0;
            tx_bit  <= '0;
            gap_cnt <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        n_q    <= dev_cnt;
                        rd_q   <= rd_nwr;
                        half_q <= (sclk_half == '0) ? HALF_W'(1) : sclk_half;
                        dly_q  <= sample_dly;
                        tx_seg <= '0;
                        tx_bit <= '0;
                        state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (fall) begin
                        if (tx_bit == BIT_W'(SEG_W - 1)) begin
                            tx_bit <= '0;
                            if (tx_seg == seg_last)
                                state <= ST_TAIL;
                            else
                                tx_seg <= tx_seg + 1'b1;
                        end else begin
                            tx_bit <= tx_bit + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (all_rx) begin
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_cnt == gap_last) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: out-of-range counts never open a frame
    a_r2_reject_count: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (dev_cnt == '0 || dev_cnt > MAX_N)) |=> !busy);

    // R10: pins rest when no frame is running
    a_r10_idle_pins: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_cs_n && !spi_sclk));

    // R10: single-cycle completion, coincident with busy dropping
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    a_r10_done_idle:   assert property (@(posedge clk) disable iff (rst) done |-> !busy);

    // R6: data is held while the serial clock stays high
    a_r6_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R11: the latched device count cannot change mid-frame
    a_r11_count_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(n_q));

endmodule

// File: tb/sim_dchain_seq.sv
`timescale 1ns/1ps
module sim_dchain_seq;
    localparam int MAX_DEV = 8;
    localparam int HALF_W  = 8;
    localparam int DLY_W   = 3;

    typedef struct packed {
        logic [4:0] n;
        logic       rd;
        logic [7:0] half;
        logic [2:0] dly;
        logic [7:0] seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{5'd1, 1'b0, 8'd2, 3'd0, 8'd11},
        '{5'd3, 1'b1, 8'd1, 3'd0, 8'd22},
        '{5'd8, 1'b0, 8'd3, 3'd2, 8'd33},
        '{5'd8, 1'b1, 8'd4, 3'd3, 8'd44},
        '{5'd5, 1'b1, 8'd0, 3'd0, 8'd55},
        '{5'd2, 1'b0, 8'd2, 3'd1, 8'd66}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic rd_nwr = 1'b0;
    logic [4:0] dev_cnt = '0;
    logic [HALF_W-1:0] sclk_half = '0;
    logic [DLY_W-1:0] sample_dly = '0;
    logic [MAX_DEV-1:0][15:0] addr_v = '0;
    logic [MAX_DEV-1:0][15:0] wdata_v = '0;
    logic busy, done, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
    logic [MAX_DEV-1:0][15:0] rdata_out;
    logic [MAX_DEV-1:0]       status_out;
    logic [MAX_DEV-1:0][5:0]  fault_out;

    int checks = 0;
    int errors = 0;

    logic [15:0] ret_seg [0:31];
    logic [15:0] mon_seg [0:31];
    int mon_bits = 0;
    int drv_pos = 0;

    always #2 clk = ~clk;

    dchain_seq #(.MAX_DEV(MAX_DEV), .HALF_W(HALF_W), .DLY_W(DLY_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr), .dev_cnt(dev_cnt),
        .sclk_half(sclk_half), .sample_dly(sample_dly), .addr_in(addr_v),
        .wdata_in(wdata_v), .busy(busy), .done(done), .rdata_out(rdata_out),
        .status_out(status_out), .fault_out(fault_out), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // Chain model: returned stream advances one bit per falling edge.
    always @(negedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) drv_pos = 0;
        else          drv_pos = drv_pos + 1;
    end
    assign spi_miso = ret_seg[(drv_pos >> 4) & 31][15 - (drv_pos & 15)];

    // Capture of the outgoing stream on rising edges.
    always @(posedge spi_sclk) begin
        if (!spi_cs_n && mon_bits < 512) begin
            mon_seg[mon_bits >> 4] = {mon_seg[mon_bits >> 4][14:0], spi_mosi};
            mon_bits = mon_bits + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input int n, input int rd, input int half, input int dly,
                             input int seed, input int intrude);
        int heff, total, cyc, rise_cyc, hi_len, exp_words;
        bit prev_cs, hi_done;
        logic [15:0] e;
        heff  = (half == 0) ? 1 : half;
        total = (rd != 0) ? 3 * n + 1 : 2 * n + 1;
        for (int i = 0; i < MAX_DEV; i++) begin
            addr_v[i]  = {~rd[0], 15'(seed * 257 + i * 4099)};
            wdata_v[i] = 16'(seed * 613 + i * 97 + 5);
        end
        for (int s = 0; s < 32; s++)
            ret_seg[s] = (((s + seed) % 3) == 0) ? {2'b11, 6'(s * 5 + seed), 8'h00}
                                                 : {2'b00, 14'(s * 311 + seed * 7)};
        mon_bits = 0;
        @(negedge clk);
        start = 1'b1; dev_cnt = 5'(n); rd_nwr = rd[0];
        sclk_half = HALF_W'(half); sample_dly = DLY_W'(dly);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 accepted start raises busy", busy, 1);
        cyc = 0; rise_cyc = -1; prev_cs = 1'b0; hi_len = 0; hi_done = 1'b0;
        while (!done && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            if (intrude != 0) begin
                start = (cyc == intrude);
                if (cyc == intrude) begin dev_cnt = 5'd5; rd_nwr = 1'b1; end
            end
            if (spi_cs_n && !prev_cs && rise_cyc < 0) rise_cyc = cyc;
            prev_cs = spi_cs_n;
            if (spi_sclk && !hi_done) hi_len++;
            else if (!spi_sclk && hi_len > 0) hi_done = 1'b1;
        end
        start = 1'b0;
        chk(cyc < 40000, "R10 done reached", cyc, 40000);
        chk(busy == 1'b0, "R10 busy low with done", busy, 0);
        chk(rise_cyc >= 0 && (cyc - rise_cyc) >= 2 * heff, "R10 cs high gap", cyc - rise_cyc, 2 * heff);
        chk(hi_len == heff, "R6 sclk high phase", hi_len, heff);
        exp_words = (intrude != 0) ? total : total;
        chk(mon_bits == exp_words * 16, "R5 R11 frame length bits", mon_bits, exp_words * 16);
        for (int s = 0; s < total; s++) begin
            if (s == 0)            e = {2'b01, 9'b0, 5'(n)};
            else if (s <= n)       e = {rd[0], addr_v[n - s][14:0]};
            else if (s <= 2 * n)   e = wdata_v[2 * n - s];
            else                   e = 16'h0000;
            if (s == 0)          chk(mon_seg[s] == e, "R1 header word", mon_seg[s], e);
            else if (s <= n)     chk(mon_seg[s] == e, "R3 R4 address word", mon_seg[s], e);
            else                 chk(mon_seg[s] == e, "R5 data/flush word", mon_seg[s], e);
        end
        for (int i = 0; i < n; i++) begin
            e = ret_seg[total - 1 - i];
            chk(rdata_out[i] == e, "R8 R7 result slot", rdata_out[i], e);
            chk(status_out[i] == (e[15:14] == 2'b11), "R9 status flag", status_out[i], e[15:14] == 2'b11);
            chk(fault_out[i] == ((e[15:14] == 2'b11) ? e[13:8] : 6'd0), "R9 fault flags",
                fault_out[i], (e[15:14] == 2'b11) ? e[13:8] : 6'd0);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
    endtask

    task automatic try_reject(input int n);
        bit seen_done;
        @(negedge clk);
        start = 1'b1; dev_cnt = 5'(n); rd_nwr = 1'b1; sclk_half = 8'd1;
        @(negedge clk);
        start = 1'b0;
        seen_done = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (busy || !spi_cs_n || done) seen_done = 1'b1;
            @(negedge clk);
        end
        chk(!seen_done, "R2 rejected count stays idle", n, 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R10 reset busy", busy, 0);
        chk(spi_cs_n == 1'b1, "R10 reset cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R6 reset sclk", spi_sclk, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
        chk(spi_mosi == 1'b0, "R6 reset mosi", spi_mosi, 0);

        for (int v = 0; v < NV; v++)
            run_frame(VECS[v].n, VECS[v].rd, VECS[v].half, VECS[v].dly, VECS[v].seed, 0);

        try_reject(0);
        try_reject(MAX_DEV + 1);

        // R11: second request mid-frame must not alter a 2-device write
        run_frame(2, 0, 2, 1, 77, 10);
        chk(busy == 1'b0, "R11 idle after intruded frame", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule